// File: doc/BRIEF.md
# Coprocessor Instruction Dispatch Unit

This unit sits next to a host integer pipeline and decides what happens to every instruction word that belongs to the coprocessor class. Each word offered on the instruction strobe is first sorted into one of five kinds: a coprocessor data operation, a move from a host register into a coprocessor, a move from a coprocessor into a host register, a load into a coprocessor, or a store out of one. Words of any other class pass by untouched. The coprocessor number is taken from the word, and a static ownership map settles which attached slot serves it. A slot may own several numbers. When two slots own the same number, the lower slot index wins.

A claimed instruction is broadcast to the owning slot, and the unit then waits a bounded number of cycles for that slot to accept it. An accept produces a single grant pulse. Silence until the window closes, an unowned number, or a word in the reserved coprocessor extension space each produce a single undefined-instruction trap pulse instead, which lets software emulate the instruction. The decision is always complete before the grant, so the host never starts an instruction that could still trap. For loads and stores the unit also works out the transfer address and the base-register writeback value, for pre-indexed and post-indexed forms, with the offset counted in words.

Top module: `cop_dispatch`

## Requirements
- R1: On each grant or trap, `kind_onehot` names the instruction kind. Bit 0 is a data operation: bits[27:24]=1110 and bit 4=0. Bit 1 is a move into the coprocessor: 1110, bit 4=1, bit 20=0. Bit 2 is a move out of the coprocessor: 1110, bit 4=1, bit 20=1. Bit 3 is a load: bits[27:25]=110, bit 20=1. Bit 4 is a store: bits[27:25]=110, bit 20=0.
- R2: On each grant or trap, `cop_num` equals bits[11:8] of the instruction word.
- R3: A word that matches neither pattern of R1 is ignored: no broadcast, grant or trap follows, and `insn_ready` stays high. A word is taken only in a cycle where `insn_ready` is high.
- R4: Slot s owns number n when bit (s*16+n) of `CLAIM_MAP` is set, and the lowest owning slot wins. While `bcast_valid` is high, `bcast_sel` has exactly one bit set, the winner's, and `bcast_word` holds the taken word.
- R5: A word whose number no slot owns raises `trap` in the cycle after the edge that took it, with no broadcast.
- R6: A word with bits[27:23]=11000 and bit 21=0 is reserved. It traps with the timing of R5 and is never broadcast, even if its number is owned.
- R7: `grant` rises in the cycle after an edge at which `bcast_valid` is high and the selected slot's `slot_accept` bit is high. Accept bits from slots that are not selected have no effect.
- R8: When the selected slot has not accepted by the edge that ends the TIMEOUT-th broadcast cycle, `trap` rises in the next cycle. An accept at that final edge still grants.
- R9: `grant` and `trap` are one-cycle pulses and never high together. Each taken word yields exactly one of them, and `insn_ready` is high again in that same cycle.
- R10: For a load or store, `xfer_addr` is the base moved by 4*bits[7:0] when bit 24 (pre-index) is 1. The move is upward when bit 23 is 1 and downward otherwise. When bit 24 is 0, `xfer_addr` is the unmodified base.
- R11: The writeback value is the base moved by 4*bits[7:0], in the direction of bit 23 and modulo 2^32, for both indexing forms.
- R12: `wb_en` pulses together with `grant` only for a load or store with bit 21=1. It is never high with `trap` or for the other kinds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction word offered |
| insn_word | input | 32 | Instruction word |
| base_value | input | 32 | Current value of the base register named by the word |
| insn_ready | output | 1 | Unit idle, a word can be taken |
| slot_accept | input | NSLOT | Accept answer from each slot |
| bcast_valid | output | 1 | Instruction broadcast in progress |
| bcast_sel | output | NSLOT | One-hot owning slot |
| bcast_word | output | 32 | Broadcast instruction word |
| kind_onehot | output | 5 | One-hot instruction kind |
| cop_num | output | 4 | Coprocessor number |
| grant | output | 1 | Execution granted pulse |
| trap | output | 1 | Undefined-instruction trap pulse |
| xfer_addr | output | 32 | Load/store transfer address |
| wb_value | output | 32 | New base-register value |
| wb_en | output | 1 | Base writeback pulse |

## Verification
The bench targets a number owned by two slots, where a unit that picked the higher slot would broadcast to the wrong coprocessor. It also drives a stray accept from a non-selected slot, which a unit that ORed all accepts would turn into a false grant. The timeout window is probed at its last cycle and one cycle past it, to catch an off-by-one that either traps a valid late accept or waits an extra cycle. Reserved-space words with an owned number, downward post-indexing that wraps below zero, and the pre-index form without writeback expose a unit that broadcasts reserved words, gets the offset sign or scale wrong, or writes the base back when it should not.

// File: rtl/cop_pkg.sv
package cop_pkg;
  localparam int NUM_W  = 4;
  localparam int NUM_N  = 1 << NUM_W;
  localparam int KIND_W = 5;

  localparam logic [KIND_W-1:0] K_NONE   = 5'b00000;
  localparam logic [KIND_W-1:0] K_DATAOP = 5'b00001;
  localparam logic [KIND_W-1:0] K_TOCP   = 5'b00010;
  localparam logic [KIND_W-1:0] K_FROMCP = 5'b00100;
  localparam logic [KIND_W-1:0] K_LOAD   = 5'b01000;
  localparam logic [KIND_W-1:0] K_STORE  = 5'b10000;

  typedef enum logic {ST_IDLE, ST_WAIT} disp_state_e;

  // word offset scaled to bytes
  function automatic logic [31:0] ofs_bytes(input logic [7:0] ofs);
    return {22'd0, ofs, 2'b00};
  endfunction

  // base moved up or down by the scaled offset, modulo 2^32
  function automatic logic [31:0] step_base(input logic [31:0] base,
                                            input logic [7:0]  ofs,
                                            input logic        up);
    return up ? (base + ofs_bytes(ofs)) : (base - ofs_bytes(ofs));
  endfunction
endpackage

// File: rtl/cop_decode.sv
module cop_decode
  import cop_pkg::*;
(
  input  logic [7:0]        op_hi,    // word bits 27:20
  input  logic              low_bit4, // word bit 4
  output logic [KIND_W-1:0] kind,
  output logic              is_cop,
  output logic              reserved
);
  logic reg_class;
  logic mem_class;

  assign reg_class = (op_hi[7:4] == 4'b1110);
  assign mem_class = (op_hi[7:5] == 3'b110);

  always_comb begin
    kind = K_NONE;
    if (reg_class) begin
      if (!low_bit4)       kind = K_DATAOP;
      else if (op_hi[0])   kind = K_FROMCP;
      else                 kind = K_TOCP;
    end else if (mem_class) begin
      kind = op_hi[0] ? K_LOAD : K_STORE;
    end
  end

  assign is_cop   = reg_class | mem_class;
  assign reserved = (op_hi[7:3] == 5'b11000) && !op_hi[1];
endmodule

// File: rtl/cop_claim_arb.sv
module cop_claim_arb
  import cop_pkg::*;
#(
  parameter int                       NSLOT     = 4,
  parameter logic [NSLOT*NUM_N-1:0]   CLAIM_MAP = '0
)(
  input  logic [NUM_W-1:0] num,
  output logic [NSLOT-1:0] sel,
  output logic             any
);
  logic [NSLOT-1:0] hit;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [NUM_N-1:0] OWN = CLAIM_MAP[s*NUM_N +: NUM_N];
    assign hit[s] = OWN[num];
  end

  // isolate lowest set bit: lowest slot index wins
  assign sel = hit & (~hit + NSLOT'(1));
  assign any = |hit;
endmodule

// File: rtl/cop_addr_gen.sv
module cop_addr_gen
  import cop_pkg::*;
(
  input  logic [31:0] base,
  input  logic [7:0]  ofs,
  input  logic        pre,
  input  logic        up,
  input  logic        wback,
  output logic [31:0] addr,
  output logic [31:0] new_base,
  output logic        wb_req
);
  logic [31:0] moved;

  assign moved    = step_base(base, ofs, up);
  assign addr     = pre ? moved : base;
  assign new_base = moved;
  assign wb_req   = wback;
endmodule

// File: rtl/cop_dispatch.sv
module cop_dispatch
  import cop_pkg::*;
#(
  parameter int                     NSLOT     = 4,
  parameter int                     TIMEOUT   = 8,
  parameter logic [NSLOT*NUM_N-1:0] CLAIM_MAP = 64'h0140_8000_4020_0030
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                insn_valid,
  input  logic [31:0]         insn_word,
  input  logic [31:0]         base_value,
  output logic                insn_ready,
  input  logic [NSLOT-1:0]    slot_accept,
  output logic                bcast_valid,
  output logic [NSLOT-1:0]    bcast_sel,
  output logic [31:0]         bcast_word,
  output logic [KIND_W-1:0]   kind_onehot,
  output logic [NUM_W-1:0]    cop_num,
  output logic                grant,
  output logic                trap,
  output logic [31:0]         xfer_addr,
  output logic [31:0]         wb_value,
  output logic                wb_en
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  disp_state_e        st;
  logic [CNT_W-1:0]   wait_cnt;
  logic [31:0]        word_q;
  logic [KIND_W-1:0]  kind_q;
  logic [NUM_W-1:0]   num_q;
  logic [NSLOT-1:0]   sel_q;
  logic [31:0]        addr_q;
  logic [31:0]        wbv_q;
  logic               wbok_q;
  logic               grant_q;
  logic               trap_q;
  logic               wb_en_q;

  // decode of the offered word
  logic [KIND_W-1:0]  dec_kind;
  logic               dec_cop;
  logic               dec_resv;

  cop_decode u_decode (
    .op_hi    (insn_word[27:20]),
    .low_bit4 (insn_word[4]),
    .kind     (dec_kind),
    .is_cop   (dec_cop),
    .reserved (dec_resv)
  );

  logic [NSLOT-1:0]   arb_sel;
  logic               arb_any;

  cop_claim_arb #(.NSLOT(NSLOT), .CLAIM_MAP(CLAIM_MAP)) u_arb (
    .num (insn_word[11:8]),
    .sel (arb_sel),
    .any (arb_any)
  );

  logic [31:0]        ag_addr;
  logic [31:0]        ag_base;
  logic               ag_wb;

  cop_addr_gen u_addr (
    .base     (base_value),
    .ofs      (insn_word[7:0]),
    .pre      (insn_word[24]),
    .up       (insn_word[23]),
    .wback    (insn_word[21]),
    .addr     (ag_addr),
    .new_base (ag_base),
    .wb_req   (ag_wb)
  );

  // named internal events
  logic take_insn;
  logic direct_trap;
  logic accept_hit;
  logic timeout_hit;
  logic is_mem;

  assign take_insn   = (st == ST_IDLE) && insn_valid && dec_cop;
  assign direct_trap = dec_resv || !arb_any;
  assign accept_hit  = (st == ST_WAIT) && |(slot_accept & sel_q);
  assign timeout_hit = (st == ST_WAIT) && (wait_cnt == CNT_W'(TIMEOUT - 1));
  assign is_mem      = (dec_kind == K_LOAD) || (dec_kind == K_STORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      wait_cnt <= '0;
      word_q   <= '0;
      kind_q   <= K_NONE;
      num_q    <= '0;
      sel_q    <= '0;
      addr_q   <= '0;
      wbv_q    <= '0;
      wbok_q   <= 1'b0;
      grant_q  <= 1'b0;
      trap_q   <= 1'b0;
      wb_en_q  <= 1'b0;
    end else begin
      grant_q <= 1'b0;
      trap_q  <= 1'b0;
      wb_en_q <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (take_insn) begin
            word_q <= insn_word;
            kind_q <= dec_kind;
            num_q  <= insn_word[11:8];
            sel_q  <= arb_sel;
            addr_q <= ag_addr;
            wbv_q  <= ag_base;
            wbok_q <= ag_wb && is_mem;
            if (direct_trap) begin
              trap_q <= 1'b1;
            end else begin
              st       <= ST_WAIT;
              wait_cnt <= '0;
            end
          end
        end
        ST_WAIT: begin
          if (accept_hit) begin
            grant_q <= 1'b1;
            wb_en_q <= wbok_q;
            st      <= ST_IDLE;
          end else if (timeout_hit) begin
            trap_q <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            wait_cnt <= wait_cnt + CNT_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign insn_ready  = (st == ST_IDLE);
  assign bcast_valid = (st == ST_WAIT);
  assign bcast_sel   = bcast_valid ? sel_q : '0;
  assign bcast_word  = word_q;
  assign kind_onehot = kind_q;
  assign cop_num     = num_q;
  assign grant       = grant_q;
  assign trap        = trap_q;
  assign xfer_addr   = addr_q;
  assign wb_value    = wbv_q;
  assign wb_en       = wb_en_q;
endmodule

// File: rtl/cop_dispatch_chk.sv
module cop_dispatch_chk #(
  parameter int NSLOT   = 4,
  parameter int TIMEOUT = 8
)(
  input logic             clk,
  input logic             rst_n,
  input logic             insn_ready,
  input logic             bcast_valid,
  input logic [NSLOT-1:0] bcast_sel,
  input logic [6:0]       bcast_hi,   // word bits 27:21
  input logic [NSLOT-1:0] slot_accept,
  input logic             grant,
  input logic             trap,
  input logic             wb_en
);
  logic [15:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_len <= '0;
    else if (bcast_valid) run_len <= run_len + 16'd1;
    else                  run_len <= '0;
  end

  // R9
  grant_trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && trap));

  // R9
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);

  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_valid |-> ($countones(bcast_sel) == 1));

  // R7
  grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> $past(bcast_valid && ((slot_accept & bcast_sel) != '0)));

  // R6
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_valid |-> !((bcast_hi[6:2] == 5'b11000) && !bcast_hi[0]));

  // R8
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_valid |-> (run_len < 16'(TIMEOUT)));

  // R12
  wb_with_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> grant);

  // R3
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_ready |-> !bcast_valid);
endmodule

bind cop_dispatch cop_dispatch_chk #(.NSLOT(NSLOT), .TIMEOUT(TIMEOUT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .insn_ready  (insn_ready),
  .bcast_valid (bcast_valid),
  .bcast_sel   (bcast_sel),
  .bcast_hi    (bcast_word[27:21]),
  .slot_accept (slot_accept),
  .grant       (grant),
  .trap        (trap),
  .wb_en       (wb_en)
);

// File: tb/test_cop_dispatch.sv
`timescale 1ns/1ps
module test_cop_dispatch;
  localparam int NSLOT   = 4;
  localparam int TIMEOUT = 8;
  localparam logic [63:0] MAP = 64'h0140_8000_4020_0030;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              insn_valid = 1'b0;
  logic [31:0]       insn_word = '0;
  logic [31:0]       base_value = '0;
  logic [NSLOT-1:0]  slot_accept = '0;
  logic              insn_ready, bcast_valid, grant, trap, wb_en;
  logic [NSLOT-1:0]  bcast_sel;
  logic [31:0]       bcast_word, xfer_addr, wb_value;
  logic [4:0]        kind_onehot;
  logic [3:0]        cop_num;

  always #2.5 clk = ~clk;

  cop_dispatch #(.NSLOT(NSLOT), .TIMEOUT(TIMEOUT), .CLAIM_MAP(MAP)) i_cop_dispatch (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
    .base_value(base_value), .insn_ready(insn_ready), .slot_accept(slot_accept),
    .bcast_valid(bcast_valid), .bcast_sel(bcast_sel), .bcast_word(bcast_word),
    .kind_onehot(kind_onehot), .cop_num(cop_num), .grant(grant), .trap(trap),
    .xfer_addr(xfer_addr), .wb_value(wb_value), .wb_en(wb_en)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  string cur_req = "R7";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic [4:0] ref_kind(input logic [31:0] w);
    casez ({w[27:24], w[20], w[4]})
      6'b1110_?0: return 5'd1;
      6'b1110_01: return 5'd2;
      6'b1110_11: return 5'd4;
      6'b110?_1?: return 5'd8;
      6'b110?_0?: return 5'd16;
      default:    return 5'd0;
    endcase
  endfunction

  function automatic int ref_owner(input logic [3:0] n);
    for (int s = 0; s < NSLOT; s++)
      if (MAP[s*16 + int'(n)]) return s;
    return -1;
  endfunction

  bit          m_busy = 0;
  int          m_cnt, m_slot;
  logic [31:0] m_word, m_base;
  bit          e_grant, e_trap, e_wben, e_mem;
  logic [4:0]  e_kind;
  logic [3:0]  e_num;
  logic [31:0] e_addr, e_wbv;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; e_grant = 0; e_trap = 0; e_wben = 0;
    end else begin
      e_grant = 0; e_trap = 0; e_wben = 0;
      if (!m_busy) begin
        if (insn_valid && ref_kind(insn_word) != 0) begin
          int s;
          e_kind = ref_kind(insn_word);
          e_num  = insn_word[11:8];
          s = ref_owner(e_num);
          if ((insn_word[27:23] == 5'b11000 && !insn_word[21]) || s < 0) e_trap = 1;
          else begin
            m_busy = 1; m_cnt = 0; m_slot = s; m_word = insn_word; m_base = base_value;
          end
        end
      end else if (slot_accept[m_slot]) begin
        logic [31:0] d;
        logic [31:0] moved;
        e_grant = 1;
        m_busy  = 0;
        d       = 32'(m_word[7:0]) * 32'd4;
        moved   = m_word[23] ? m_base + d : m_base - d;
        e_mem   = (m_word[27:25] == 3'b110);
        e_addr  = m_word[24] ? moved : m_base;
        e_wbv   = moved;
        e_wben  = e_mem && m_word[21];
      end else if (m_cnt == TIMEOUT - 1) begin
        e_trap = 1; m_busy = 0;
      end else m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NSLOT-1:0] es;
      es = m_busy ? NSLOT'(1) << m_slot : '0;
      check(insn_ready == !m_busy, "R3", "ready", 32'(insn_ready), 32'(!m_busy));
      check(bcast_valid == m_busy, "R4", "bcast_valid", 32'(bcast_valid), 32'(m_busy));
      check(bcast_sel == es, "R4", "bcast_sel", 32'(bcast_sel), 32'(es));
      if (m_busy) check(bcast_word == m_word, "R4", "bcast_word", bcast_word, m_word);
      check(grant == e_grant, cur_req, "grant", 32'(grant), 32'(e_grant));
      check(trap == e_trap, cur_req, "trap", 32'(trap), 32'(e_trap));
      check(!(grant && trap), "R9", "grant&trap", 32'({grant, trap}), 32'b0);
      if (e_grant || e_trap) begin
        check(kind_onehot == e_kind, "R1", "kind", 32'(kind_onehot), 32'(e_kind));
        check(cop_num == e_num, "R2", "cop_num", 32'(cop_num), 32'(e_num));
      end
      check(wb_en == e_wben, "R12", "wb_en", 32'(wb_en), 32'(e_wben));
      if (e_grant && e_mem) check(xfer_addr == e_addr, "R10", "xfer_addr", xfer_addr, e_addr);
      if (e_wben) check(wb_value == e_wbv, "R11", "wb_value", wb_value, e_wbv);
    end
  end

  // ---------------- slot responders ----------------
  int lat[NSLOT];
  int seen[NSLOT];
  logic [NSLOT-1:0] stray = '0;

  always @(negedge clk) begin
    for (int s = 0; s < NSLOT; s++) begin
      if (bcast_valid && bcast_sel[s]) begin
        slot_accept[s] = (seen[s] >= lat[s]) || stray[s];
        seen[s]++;
      end else begin
        seen[s] = 0;
        slot_accept[s] = stray[s];
      end
    end
  end

  // ---------------- word builders ----------------
  function automatic logic [31:0] w_dop(input logic [3:0] cp);
    return {4'hE, 4'hE, 4'h2, 4'hA, 4'hC, cp, 3'd4, 1'b0, 4'h3};
  endfunction
  function automatic logic [31:0] w_mov(input logic [3:0] cp, input logic out);
    return {4'hE, 4'hE, 3'd1, out, 4'h7, 4'h7, cp, 3'd6, 1'b1, 4'hC};
  endfunction
  function automatic logic [31:0] w_mem(input logic p, input logic u, input logic wb,
                                        input logic ld, input logic [3:0] cp,
                                        input logic [7:0] ofs);
    return {4'hE, 3'b110, p, u, 1'b0, wb, ld, 4'h2, 4'h4, cp, ofs};
  endfunction

  task automatic issue(input logic [31:0] w, input logic [31:0] b);
    @(negedge clk);
    insn_valid = 1'b1; insn_word = w; base_value = b;
    @(negedge clk);
    insn_valid = 1'b0;
    for (int i = 0; i < 4 * TIMEOUT && !insn_ready; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    for (int s = 0; s < NSLOT; s++) lat[s] = 0;
    repeat (3) @(negedge clk);
    // reset state, R9 and R3
    check(insn_ready == 1'b1 && bcast_valid == 1'b0, "R3", "reset ready", 32'({insn_ready, bcast_valid}), 32'b10);
    check(grant == 1'b0 && trap == 1'b0, "R9", "reset pulses", 32'({grant, trap}), 32'b0);
    rst_n = 1'b1;

    // R3: foreign words ignored
    cur_req = "R3";
    issue(32'hE081_2003, 32'h0);
    issue(32'hEF00_0011, 32'h0);
    issue(32'hEA00_0010, 32'h0);

    // R4/R1: number 5 owned by slots 0 and 1, slot 0 wins; stray accept from slot 1
    cur_req = "R7";
    stray = 4'b0010;
    issue(w_dop(4'd5), 32'h0);
    // R7: winner silent, stray accept ignored -> trap by timeout
    lat[0] = 100;
    issue(w_dop(4'd5), 32'h0);
    stray = '0; lat[0] = 0;

    // R1: register moves both directions
    lat[1] = 2;
    issue(w_mov(4'd14, 1'b0), 32'h0);
    issue(w_mov(4'd15, 1'b1), 32'h0);

    // R5: unowned number
    cur_req = "R5";
    issue(w_dop(4'd7), 32'h0);
    issue(w_mem(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 8'h01), 32'h100);

    // R6: reserved space with owned number
    cur_req = "R6";
    issue(w_mem(1'b0, 1'b0, 1'b0, 1'b1, 4'd6, 8'h10), 32'h500);
    issue(w_mem(1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 8'h02), 32'h500);

    // R10/R11/R12: addressing forms
    cur_req = "R10";
    lat[3] = 1;
    issue(w_mem(1'b1, 1'b1, 1'b1, 1'b1, 4'd8, 8'h03), 32'h0000_1000);
    cur_req = "R11";
    issue(w_mem(1'b0, 1'b0, 1'b1, 1'b0, 4'd6, 8'h04), 32'h0000_2000);
    issue(w_mem(1'b0, 1'b0, 1'b1, 1'b1, 4'd8, 8'hFF), 32'h0000_0004);
    cur_req = "R12";
    issue(w_mem(1'b1, 1'b0, 1'b0, 1'b1, 4'd4, 8'h02), 32'h0000_0040);
    issue(w_mem(1'b0, 1'b1, 1'b0, 1'b0, 4'd5, 8'h09), 32'h0000_0080);

    // R8: accept in the final cycle grants, one later traps
    cur_req = "R8";
    lat[2] = TIMEOUT - 1;
    issue(w_mov(4'd15, 1'b0), 32'h0);
    lat[2] = TIMEOUT;
    issue(w_mov(4'd15, 1'b1), 32'h0);
    lat[2] = 0;

    // R9: back-to-back mix
    cur_req = "R9";
    issue(w_dop(4'd4), 32'h0);
    issue(w_dop(4'd9), 32'h0);
    issue(w_mem(1'b1, 1'b1, 1'b0, 1'b0, 4'd14, 8'h20), 32'h8000_0000);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule